// File: doc/BRIEF.md
# Speculative Chunk Window Commit Controller

This controller runs one loop of speculative iterations across a set of worker nodes. The iteration space is split into chunks: runs of consecutive iteration numbers, each no larger than a programmed chunk size. Any idle node that asks for work gets the next chunk. Every chunk handed out joins an ordered window, with the oldest (least speculative) chunk at the head and the newest at the tail.

When a node reports that its chunk has finished, the chunk is marked finished in the window. It is committed only when it becomes the head of the window. A commit is a writeback request that carries the owning node and the first iteration of the chunk, and the chunk then leaves the window. Finished chunks that queued up behind a slow head commit one per cycle, back to back, once the head retires.

A dependence violation reported against a running chunk removes that chunk and every younger chunk in the same cycle. All of their nodes receive a restart pulse at once, and chunk issue resumes from the first iteration of the faulting chunk. Each window instance serves one job, and every grant and commit carries that job's tag.

Top module: `spec_chunk_window`

## Requirements
- R1: While reset is held, grant_vld, commit_vld, restart_mask and loop_done are all zero, even with every node requesting.
- R2: While a run is active, the lowest-numbered node that requests and owns no running chunk is granted in the same cycle. At most one grant is made per cycle. grant_node is the binary node number.
- R3: Chunk bases start at 0 and advance by the length of each grant. The length is the smaller of the chunk size and the iterations left before the limit. A chunk size of 0 acts as 1. No grant is made once the base reaches the limit.
- R4: No grant is made while the window holds DEPTH chunks. A requesting node keeps waiting until a commit or a squash frees a slot.
- R5: A done pulse from a node that owns no running chunk has no effect.
- R6: commit_vld is high exactly when the head chunk is finished. It names the head's node and base, and retires one chunk per cycle. A chunk whose done pulse arrives in cycle t can commit in cycle t+1 at the earliest. Commits follow grant order.
- R7: A squash naming a node with a running chunk removes that chunk and all younger ones in that cycle. In the same cycle restart_mask shows every node that owned one of the removed running chunks, and no grant is made. The next grant starts at the faulting chunk's base. A squash naming an idle node has no effect.
- R8: loop_done is high while a run is active, every iteration has been issued and the window is empty.
- R9: grant_job and commit_job equal the job_id sampled by the start that was accepted.
- R10: A start pulse is accepted only when no run is active or loop_done is high. Otherwise it is ignored and the limit, chunk size and job tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with the values below |
| job_id | input | JOB_W | Job tag for the run |
| iter_limit | input | ITER_W | Number of iterations in the loop |
| chunk_size | input | ITER_W | Iterations per chunk (0 acts as 1) |
| node_req | input | NODES | Node asks for a chunk |
| node_done | input | NODES | Node finished its running chunk |
| squash_vld | input | 1 | Violation reported against a node's running chunk |
| squash_node | input | NODE_W | Node whose chunk is faulting |
| grant_vld | output | 1 | A chunk is handed out this cycle |
| grant_node | output | NODE_W | Node receiving the chunk |
| grant_base | output | ITER_W | First iteration of the chunk |
| grant_len | output | ITER_W | Iterations in the chunk |
| grant_job | output | JOB_W | Job tag of the chunk |
| commit_vld | output | 1 | Writeback request for the head chunk |
| commit_node | output | NODE_W | Node owning the committing chunk |
| commit_base | output | ITER_W | First iteration of the committing chunk |
| commit_job | output | JOB_W | Job tag of the committing chunk |
| restart_mask | output | NODES | Nodes whose running chunks were squashed |
| loop_done | output | 1 | All iterations issued and committed |

## Verification
The first run has evenly fast nodes and no faults. It shows the in-order grant and commit sequence and the rounding of the last chunk. Another run gives a slow node 0 a long head chunk while the other nodes finish quickly. This fills the window, stalls grants at the DEPTH cap, and then releases a burst of back-to-back commits. That run also injects done pulses from idle nodes and a start pulse in the middle of the run, to show both have no effect. A third run squashes random nodes, some of them idle, so the bench sees how younger chunks and their nodes are cut and where issue resumes. A short run with chunk size 0 covers one-iteration chunks.

// File: rtl/swin_pkg.sv
package swin_pkg;
   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_RUN  = 1'b1
   } win_state_e;
endpackage

// File: rtl/swin_pick.sv
module swin_pick #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/swin_ring.sv
module swin_ring #(
   parameter int DEPTH  = 8,
   parameter int NODE_W = 2,
   parameter int ITER_W = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [NODE_W-1:0] push_node,
   input  logic [ITER_W-1:0] push_base,
   input  logic              pop,
   input  logic [DEPTH-1:0]  mark_mask,
   input  logic              cut,
   input  logic [PTR_W-1:0]  cut_slot,
   output logic [PTR_W-1:0]  head_ptr,
   output logic [PTR_W-1:0]  tail_ptr,
   output logic [CNT_W-1:0]  count,
   output logic [NODE_W-1:0] head_node,
   output logic [ITER_W-1:0] head_base,
   output logic              head_done,
   output logic [ITER_W-1:0] cut_base
);
   logic [NODE_W-1:0] nd_q [DEPTH];
   logic [ITER_W-1:0] bs_q [DEPTH];
   logic [DEPTH-1:0]  dn_q;
   logic [PTR_W-1:0]  cut_off;

   assign cut_off = cut_slot - head_ptr;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            nd_q[i] <= '0;
            bs_q[i] <= '0;
            dn_q[i] <= 1'b0;
         end else if (push && tail_ptr == PTR_W'(i)) begin
            nd_q[i] <= push_node;
            bs_q[i] <= push_base;
            dn_q[i] <= 1'b0;
         end else if (mark_mask[i]) begin
            dn_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         head_ptr <= '0;
         tail_ptr <= '0;
         count    <= '0;
      end else begin
         head_ptr <= head_ptr + PTR_W'(pop);
         if (cut) begin
            tail_ptr <= cut_slot;
            count    <= {1'b0, cut_off} - CNT_W'(pop);
         end else begin
            tail_ptr <= tail_ptr + PTR_W'(push);
            count    <= count + CNT_W'(push) - CNT_W'(pop);
         end
      end
   end

   assign head_node = nd_q[head_ptr];
   assign head_base = bs_q[head_ptr];
   assign head_done = dn_q[head_ptr];
   assign cut_base  = bs_q[cut_slot];

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)));
   p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
endmodule

// File: rtl/spec_chunk_window.sv
module spec_chunk_window
   import swin_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int DEPTH  = 8,
   parameter int ITER_W = 16,
   parameter int JOB_W  = 4,
   localparam int NODE_W = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [JOB_W-1:0]  job_id,
   input  logic [ITER_W-1:0] iter_limit,
   input  logic [ITER_W-1:0] chunk_size,
   input  logic [NODES-1:0]  node_req,
   input  logic [NODES-1:0]  node_done,
   input  logic              squash_vld,
   input  logic [NODE_W-1:0] squash_node,
   output logic              grant_vld,
   output logic [NODE_W-1:0] grant_node,
   output logic [ITER_W-1:0] grant_base,
   output logic [ITER_W-1:0] grant_len,
   output logic [JOB_W-1:0]  grant_job,
   output logic              commit_vld,
   output logic [NODE_W-1:0] commit_node,
   output logic [ITER_W-1:0] commit_base,
   output logic [JOB_W-1:0]  commit_job,
   output logic [NODES-1:0]  restart_mask,
   output logic              loop_done
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (NODES < 2) begin : g_bad_nodes
      $error("spec_chunk_window: NODES must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spec_chunk_window: DEPTH must be a power of two, at least 2");
   end
   if (DEPTH < NODES) begin : g_bad_ratio
      $error("spec_chunk_window: DEPTH must cover every node");
   end

   win_state_e        st;
   logic [ITER_W-1:0] next_iter, lim_q, csz_q;
   logic [JOB_W-1:0]  job_q;
   logic [NODES-1:0]  busy;
   logic [PTR_W-1:0]  slot_q [NODES];

   logic [PTR_W-1:0]  head_ptr, tail_ptr, cut_slot, cut_off;
   logic [CNT_W-1:0]  count;
   logic [NODE_W-1:0] head_node;
   logic [ITER_W-1:0] head_base, cut_base, csz_eff, remain, glen;
   logic              head_done, exhausted, start_ok, sq_hit, can_grant;
   logic [NODES-1:0]  kill, cand, gnt_oh;
   logic [NODE_W-1:0] gnt_idx;
   logic              gnt_any;
   logic [DEPTH-1:0]  mark;

   assign exhausted = next_iter >= lim_q;
   assign loop_done = (st == WIN_RUN) && exhausted && (count == '0);
   assign start_ok  = start && ((st == WIN_IDLE) || loop_done);
   assign sq_hit    = squash_vld && (int'(squash_node) < NODES) && busy[squash_node];
   assign cut_slot  = slot_q[squash_node];
   assign cut_off   = cut_slot - head_ptr;

   always_comb begin
      for (int n = 0; n < NODES; n++) begin
         kill[n] = sq_hit && busy[n] && (PTR_W'(slot_q[n] - head_ptr) >= cut_off);
      end
   end

   assign can_grant = (st == WIN_RUN) && !exhausted && (count < CNT_W'(DEPTH)) && !sq_hit;
   assign cand      = node_req & ~busy & {NODES{can_grant}};

   swin_pick #(.N(NODES)) u_pick (
      .req (cand),
      .gnt (gnt_oh),
      .idx (gnt_idx),
      .any (gnt_any)
   );

   assign csz_eff = (csz_q == '0) ? ITER_W'(1) : csz_q;
   assign remain  = lim_q - next_iter;
   assign glen    = (csz_eff > remain) ? remain : csz_eff;

   always_comb begin
      mark = '0;
      for (int n = 0; n < NODES; n++) begin
         if (node_done[n] && busy[n] && !kill[n]) mark[slot_q[n]] = 1'b1;
      end
   end

   assign commit_vld = (count != '0) && head_done;

   swin_ring #(.DEPTH(DEPTH), .NODE_W(NODE_W), .ITER_W(ITER_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_ok),
      .push      (gnt_any),
      .push_node (gnt_idx),
      .push_base (next_iter),
      .pop       (commit_vld),
      .mark_mask (mark),
      .cut       (sq_hit),
      .cut_slot  (cut_slot),
      .head_ptr  (head_ptr),
      .tail_ptr  (tail_ptr),
      .count     (count),
      .head_node (head_node),
      .head_base (head_base),
      .head_done (head_done),
      .cut_base  (cut_base)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= WIN_IDLE;
         next_iter <= '0;
         lim_q     <= '0;
         csz_q     <= '0;
         job_q     <= '0;
      end else if (start_ok) begin
         st        <= WIN_RUN;
         next_iter <= '0;
         lim_q     <= iter_limit;
         csz_q     <= chunk_size;
         job_q     <= job_id;
      end else if (sq_hit) begin
         next_iter <= cut_base;
      end else if (gnt_any) begin
         next_iter <= next_iter + glen;
      end
   end

   for (genvar n = 0; n < NODES; n++) begin : g_node
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[n]   <= 1'b0;
            slot_q[n] <= '0;
         end else if (kill[n] || (node_done[n] && busy[n])) begin
            busy[n]   <= 1'b0;
         end else if (gnt_oh[n]) begin
            busy[n]   <= 1'b1;
            slot_q[n] <= tail_ptr;
         end
      end
   end

   assign grant_vld    = gnt_any;
   assign grant_node   = gnt_idx;
   assign grant_base   = next_iter;
   assign grant_len    = glen;
   assign grant_job    = job_q;
   assign commit_node  = head_node;
   assign commit_base  = head_base;
   assign commit_job   = job_q;
   assign restart_mask = kill;

   logic [ITER_W-1:0] last_cbase;
   logic              have_c;
   always_ff @(posedge clk) begin
      if (!rst_n || start_ok) begin
         have_c     <= 1'b0;
         last_cbase <= '0;
      end else if (commit_vld) begin
         have_c     <= 1'b1;
         last_cbase <= commit_base;
      end
   end

   p_pick_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_oh));
   p_grant_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> ((grant_len != '0) &&
         ({1'b0, grant_base} + {1'b0, grant_len} <= {1'b0, lim_q})));
   p_commit_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && have_c) |-> (commit_base > last_cbase));
   p_room_after_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|restart_mask) |=> (count < CNT_W'(DEPTH)));
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |-> (!commit_vld && !grant_vld && restart_mask == '0));
endmodule

// File: tb/spec_chunk_window_bench.sv
module spec_chunk_window_bench;
   localparam int NN = 4;
   localparam int DP = 8;
   localparam int IW = 16;
   localparam int JW = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, start, squash_vld, grant_vld, commit_vld, loop_done;
   logic [JW-1:0] job_id, grant_job, commit_job;
   logic [IW-1:0] iter_limit, chunk_size, grant_base, grant_len, commit_base;
   logic [NN-1:0] node_req, node_done, restart_mask;
   logic [1:0]    squash_node, grant_node, commit_node;

   spec_chunk_window #(.NODES(NN), .DEPTH(DP), .ITER_W(IW), .JOB_W(JW)) u_spec_chunk_window (
      .clk(clk), .rst_n(rst_n), .start(start), .job_id(job_id),
      .iter_limit(iter_limit), .chunk_size(chunk_size),
      .node_req(node_req), .node_done(node_done),
      .squash_vld(squash_vld), .squash_node(squash_node),
      .grant_vld(grant_vld), .grant_node(grant_node), .grant_base(grant_base),
      .grant_len(grant_len), .grant_job(grant_job),
      .commit_vld(commit_vld), .commit_node(commit_node), .commit_base(commit_base),
      .commit_job(commit_job), .restart_mask(restart_mask), .loop_done(loop_done)
   );

   int checks = 0;
   int errs   = 0;

   task automatic chk(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errs++;
         $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   typedef struct {int node; int base; bit done; int id;} ent_t;
   ent_t q[$];
   int   m_busy[NN];
   int   tmr[NN];
   bit   m_act;
   int   m_next, m_lim, m_cs, m_job, seq;
   bit   stray_prev, mid_seen;

   function automatic int find_id(int id);
      foreach (q[i]) if (q[i].id == id) return i;
      return -1;
   endfunction

   task automatic run(int job, int lim, int cs, int slow0, int sq_rate, bit stray, bit midstart);
      bit fin = 0;
      int tail = 0;
      stray_prev = 0;
      mid_seen   = 0;
      for (int c = 0; c < 20000 && tail < 3; c++) begin
         bit e_ld, e_st, e_sq, e_cv, e_gv, stray_now;
         int k, ekill, gn, glen, cse;
         // drive inputs
         start      = (c == 0) || (midstart && c == 12);
         job_id     = JW'((c == 0) ? job : job + 1);
         iter_limit = IW'((c == 0) ? lim : lim + 7);
         chunk_size = IW'((c == 0) ? cs : cs + 1);
         stray_now  = 0;
         for (int n = 0; n < NN; n++) begin
            if (m_busy[n] >= 0) begin
               node_req[n]  = 1'b0;
               node_done[n] = (tmr[n] == 0);
            end else begin
               node_req[n]  = m_act && ($urandom % 4 != 0);
               node_done[n] = stray && ($urandom % 6 == 0);
               if (node_done[n]) stray_now = 1;
            end
         end
         squash_vld  = (sq_rate > 0) && ($urandom % sq_rate == 0);
         squash_node = 2'($urandom % NN);
         #2;
         // expected outputs
         e_ld = m_act && m_next >= m_lim && q.size() == 0;
         e_st = start && (!m_act || e_ld);
         if (start && !e_st) mid_seen = 1;
         e_cv = q.size() > 0 && q[0].done;
         e_sq = squash_vld && m_busy[squash_node] >= 0;
         k = e_sq ? find_id(m_busy[squash_node]) : -1;
         ekill = 0;
         if (e_sq) for (int n = 0; n < NN; n++)
            if (m_busy[n] >= 0 && find_id(m_busy[n]) >= k) ekill |= (1 << n);
         cse  = (m_cs == 0) ? 1 : m_cs;
         glen = (cse > m_lim - m_next) ? m_lim - m_next : cse;
         gn = -1;
         if (m_act && !e_sq && q.size() < DP && m_next < m_lim)
            for (int n = NN - 1; n >= 0; n--) if (node_req[n] && m_busy[n] < 0) gn = n;
         e_gv = (gn >= 0);
         chk((q.size() == DP) ? "R4" : "R2", "grant_vld", int'(grant_vld), int'(e_gv));
         if (e_gv && grant_vld) begin
            chk("R2", "grant_node", int'(grant_node), gn);
            chk(mid_seen ? "R10" : "R3", "grant_base", int'(grant_base), m_next);
            chk("R3", "grant_len", int'(grant_len), glen);
            chk("R9", "grant_job", int'(grant_job), m_job);
         end
         chk(stray_prev ? "R5" : "R6", "commit_vld", int'(commit_vld), int'(e_cv));
         if (e_cv && commit_vld) begin
            chk("R6", "commit_node", int'(commit_node), q[0].node);
            chk("R6", "commit_base", int'(commit_base), q[0].base);
            chk("R9", "commit_job", int'(commit_job), m_job);
         end
         chk("R7", "restart_mask", int'(restart_mask), ekill);
         chk("R8", "loop_done", int'(loop_done), int'(e_ld));
         if (e_ld && c > 0) fin = 1;
         if (fin) tail++;
         @(posedge clk);
         // model update
         if (e_st) begin
            m_act = 1; m_next = 0; m_lim = lim; m_cs = cs; m_job = job;
         end else begin
            if (e_sq) begin
               m_next = q[k].base;
               while (q.size() > k) void'(q.pop_back());
               for (int n = 0; n < NN; n++) if (ekill[n]) m_busy[n] = -1;
            end
            for (int n = 0; n < NN; n++)
               if (node_done[n] && m_busy[n] >= 0) begin
                  q[find_id(m_busy[n])].done = 1;
                  m_busy[n] = -1;
               end
            if (e_cv) void'(q.pop_front());
            if (e_gv) begin
               q.push_back('{node: gn, base: m_next, done: 0, id: seq});
               m_busy[gn] = seq;
               seq++;
               m_next += glen;
               tmr[gn] = 1 + int'($urandom % 4) + ((gn == 0) ? slow0 : 0);
            end
         end
         for (int n = 0; n < NN; n++) if (m_busy[n] >= 0 && tmr[n] > 0) tmr[n]--;
         stray_prev = stray_now;
         @(negedge clk);
      end
      start = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL R8 watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      rst_n = 0; start = 0; job_id = '0; iter_limit = '0; chunk_size = '0;
      node_req = '1; node_done = '0; squash_vld = 0; squash_node = '0;
      m_act = 0; m_next = 0; m_lim = 0; m_cs = 0; m_job = 0; seq = 0;
      for (int n = 0; n < NN; n++) begin m_busy[n] = -1; tmr[n] = 0; end
      repeat (3) @(negedge clk);
      #2;
      chk("R1", "grant_vld", int'(grant_vld), 0);
      chk("R1", "commit_vld", int'(commit_vld), 0);
      chk("R1", "restart_mask", int'(restart_mask), 0);
      chk("R1", "loop_done", int'(loop_done), 0);
      @(negedge clk);
      rst_n = 1;
      node_req = '0;
      run(3, 20, 3, 0, 0, 0, 0);
      run(5, 200, 2, 60, 0, 1, 1);
      run(9, 150, 4, 0, 15, 1, 0);
      run(6, 5, 0, 0, 0, 0, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule